// File: doc/BRIEF.md
# Sector Write-Protection Checker

This block decides, one request at a time, whether a program or erase to a word address may go ahead. It turns the word address into a sector number. The sector map has eight small 4-Kword boot sectors at the bottom of the address space, eight more at the top, and uniform 32-Kword sectors in between. With the default 22-bit word address (4M words) the map holds 142 sectors.

Several protection layers decide the verdict. The first is a bit per sector that keeps its state through reset. The second is a password mode: once it is entered, clearing those bits needs a prior unlock with a matching 64-bit value. The last two are pins. An active-low guard pin shields the two lowest and two highest boot sectors. An active-low boost pin locks the whole array.

The verdict and the sector number come out registered, one cycle after the request. A small configuration port sets and clears sector locks, loads the password, enters password mode and presents unlock attempts. The command decoder, the array and the program and erase timing all sit outside this block.

Top module: `sp_write_guard`

## Requirements
- R1: Word addresses below 0x8000 map to sector addr[14:12] (0 to 7). Addresses from 0x3F8000 up map to sector 134 + addr[14:12] (134 to 141). Every other address maps to sector (addr >> 15) + 7 (8 to 133).
- R2: A request sampled with req_valid high produces rsp_valid high, with its verdict and sector number, on the next clock edge. Without a request, rsp_valid is low on the next edge.
- R3: While outer_guard_n is low, requests to sectors 0, 1, 140 and 141 are denied (rsp_allow low). Other sectors are not affected by this pin.
- R4: While boost_n is low, every request is denied.
- R5: cfg_op 1 locks the sector given by cfg_sector, and requests to a locked sector are denied. Out-of-range sector numbers (142 and up) change nothing.
- R6: Outside password mode, cfg_op 2 unlocks the sector given by cfg_sector, and cfg_op 3 unlocks all sectors.
- R7: cfg_op 6 enters password mode, and nothing leaves it. In password mode, cfg_op 2 and 3 have no effect unless the unlock latch is set. cfg_op 5 sets the latch when cfg_data equals the stored password and clears it otherwise.
- R8: cfg_op 4 stores cfg_data as the password only outside password mode. Inside password mode it is ignored.
- R9: Reset clears the unlock latch and the response register. It keeps the sector lock bits, the password and the mode.
- R10: A request is judged on the protection state before any configuration write in the same cycle takes effect.
- R11: A request is allowed only when no pin rule and no sector lock denies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Program/erase request strobe |
| req_addr | input | 22 | Word address of the request |
| outer_guard_n | input | 1 | Low shields the four outermost boot sectors |
| boost_n | input | 1 | Low locks every sector |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Configuration operation code |
| cfg_sector | input | 8 | Sector number for lock and unlock operations |
| cfg_data | input | 64 | Password value for load and unlock attempts |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_allow | output | 1 | High when the request may proceed |
| rsp_sector | output | 8 | Sector number of the request |

## Verification
The bench probes the map boundaries: the last and first word of each boot region and the first and last large sector. A decoder off by one slot would report sector 8 for address 0x7FFF, or 133 for 0x3F8000. The guard pin is tested on sectors 2 and 139, right next to the shielded ones. A design that shields a whole boot region, or only one end, shows up there.

In password mode the bench tries a wrong unlock, then a correct one followed by a wrong one. It also loads a new password inside the mode and then resets. A design that keeps the latch after a mismatch, lets a password load replace the stored one, or drops lock bits on reset would let the clear through, or would let the second password unlock. A lock written in the same cycle as a request to that sector must not change that verdict.

// File: rtl/sp_pkg.sv
// Shared definitions for the sector write-protection checker.
// Assumes 16-bit words addressed by word; sizes are given as log2 of words.
package sp_pkg;

    // Configuration operation codes on the cfg port.
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_LOCK     = 3'd1,
        OP_FREE     = 3'd2,
        OP_FREE_ALL = 3'd3,
        OP_PWD_LOAD = 3'd4,
        OP_PWD_TRY  = 3'd5,
        OP_PWD_MODE = 3'd6,
        OP_RSVD     = 3'd7
    } cfg_op_e;

    // Number of sectors for a map with small sectors at both ends.
    function automatic int sector_count(int addr_w, int big_w, int boot_w);
        return 2 * (1 << (big_w - boot_w)) + (1 << (addr_w - big_w)) - 2;
    endfunction

endpackage

// File: rtl/sp_sector_decode.sv
// Sector decoder: maps a word address onto a sector number.
// Assumes the lowest and highest large-sector slots are each split into
// small boot sectors, and all other slots are one large sector each.
module sp_sector_decode #(
    parameter int ADDR_W    = 22,
    parameter int BIG_W     = 15,
    parameter int BOOT_W    = 12,
    parameter int OUTER_END = 2,
    parameter int NSEC      = sp_pkg::sector_count(ADDR_W, BIG_W, BOOT_W),
    parameter int SIDX_W    = $clog2(NSEC)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SIDX_W-1:0] sector,
    output logic              is_outer
);
    localparam int SLOT_W = ADDR_W - BIG_W;
    localparam int SUB_W  = BIG_W - BOOT_W;
    localparam int BOOT_N = 1 << SUB_W;
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int TOP_BASE = BOOT_N + SLOTS - 2;

    logic [SLOT_W-1:0] slot;
    logic [SUB_W-1:0]  sub;

    assign slot = addr[ADDR_W-1:BIG_W];
    assign sub  = addr[BIG_W-1:BOOT_W];

    // Pick the sector number from the slot, splitting the two end slots.
    always_comb begin
        if (slot == '0) begin
            sector = SIDX_W'(sub);
        end else if (slot == SLOT_W'(SLOTS - 1)) begin
            sector = SIDX_W'(TOP_BASE) + SIDX_W'(sub);
        end else begin
            sector = SIDX_W'(slot) + SIDX_W'(BOOT_N - 1);
        end
    end

    // Flag the outermost boot sectors at either end of the map.
    always_comb begin
        is_outer = (sector < SIDX_W'(OUTER_END)) ||
                   (sector >= SIDX_W'(NSEC - OUTER_END));
    end

endmodule

// File: rtl/sp_pwd_ctrl.sv
// Password control: stores the password and the one-way mode flag, and
// keeps the unlock latch that permits clearing locks in password mode.
// Assumes the password and the mode are non-volatile: reset leaves them alone.
module sp_pwd_ctrl #(
    parameter int PWD_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  sp_pkg::cfg_op_e  cfg_op,
    input  logic [PWD_W-1:0] cfg_data,
    output logic             clr_permit
);
    import sp_pkg::*;

    logic [PWD_W-1:0] pwd_q      = '1;
    logic             pwd_mode_q = 1'b0;
    logic             unlock_q;

    // Non-volatile password store and one-way mode flag.
    always_ff @(posedge clk) begin
        if (cfg_valid && cfg_op == OP_PWD_LOAD && !pwd_mode_q) begin
            pwd_q <= cfg_data;
        end
        if (cfg_valid && cfg_op == OP_PWD_MODE) begin
            pwd_mode_q <= 1'b1;
        end
    end

    // Unlock latch: set by a matching attempt, cleared by a miss or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
        end else if (cfg_valid && cfg_op == OP_PWD_TRY) begin
            unlock_q <= (cfg_data == pwd_q);
        end
    end

    assign clr_permit = !pwd_mode_q || unlock_q;

    // A missed attempt leaves the latch cleared.
    assert_miss_clears_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_op == OP_PWD_TRY && cfg_data != pwd_q) |=> !unlock_q);

    // The latch only rises after an attempt.
    assert_latch_needs_try_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_q) |-> $past(cfg_valid && cfg_op == OP_PWD_TRY));

    // A load inside password mode leaves the stored value unchanged.
    assert_load_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_op == OP_PWD_LOAD && pwd_mode_q) |=> $stable(pwd_q));

endmodule

// File: rtl/sp_lock_store.sv
// Lock store: one non-volatile lock bit per sector, set and cleared through
// the configuration port. Clearing needs the permit from password control.
// Assumes out-of-range sector numbers select no bit.
module sp_lock_store #(
    parameter int NSEC   = 142,
    parameter int SIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  sp_pkg::cfg_op_e   cfg_op,
    input  logic [SIDX_W-1:0] cfg_sector,
    input  logic              clr_permit,
    input  logic [SIDX_W-1:0] rd_sector,
    output logic              rd_locked
);
    import sp_pkg::*;

    logic [NSEC-1:0] lock_q = '0;
    logic [NSEC-1:0] hit;
    logic [NSEC-1:0] set_mask;
    logic [NSEC-1:0] clr_mask;
    logic            do_set;
    logic            do_clr_one;
    logic            do_clr_all;

    assign do_set     = cfg_valid && cfg_op == OP_LOCK;
    assign do_clr_one = cfg_valid && cfg_op == OP_FREE && clr_permit;
    assign do_clr_all = cfg_valid && cfg_op == OP_FREE_ALL && clr_permit;

    // One select line per sector, plus its set and clear masks.
    for (genvar i = 0; i < NSEC; i++) begin : g_sel
        assign hit[i]      = (cfg_sector == SIDX_W'(i));
        assign set_mask[i] = do_set && hit[i];
        assign clr_mask[i] = do_clr_all || (do_clr_one && hit[i]);
    end

    // Non-volatile lock bits: reset leaves them untouched.
    always_ff @(posedge clk) begin
        lock_q <= (lock_q | set_mask) & ~clr_mask;
    end

    assign rd_locked = (rd_sector < SIDX_W'(NSEC)) ? lock_q[rd_sector] : 1'b1;

    // A clear without permit keeps a locked sector locked.
    assert_clear_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_op == OP_FREE && !clr_permit &&
         cfg_sector < SIDX_W'(NSEC) && lock_q[cfg_sector])
        |=> lock_q[$past(cfg_sector)]);

    // A lock write takes hold on the next edge.
    assert_lock_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_op == OP_LOCK && cfg_sector < SIDX_W'(NSEC))
        |=> lock_q[$past(cfg_sector)]);

endmodule

// File: rtl/sp_write_guard.sv
// Sector write-protection checker (top). Decodes the request address,
// combines pin rules with sector locks and registers the verdict.
// Assumes one request per cycle and no back-pressure.
module sp_write_guard #(
    parameter int ADDR_W    = 22,
    parameter int BIG_W     = 15,
    parameter int BOOT_W    = 12,
    parameter int PWD_W     = 64,
    parameter int OUTER_END = 2,
    localparam int NSEC     = sp_pkg::sector_count(ADDR_W, BIG_W, BOOT_W),
    localparam int SIDX_W   = $clog2(NSEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              outer_guard_n,
    input  logic              boost_n,
    input  logic              cfg_valid,
    input  logic [2:0]        cfg_op,
    input  logic [SIDX_W-1:0] cfg_sector,
    input  logic [PWD_W-1:0]  cfg_data,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic [SIDX_W-1:0] rsp_sector
);
    import sp_pkg::*;

    cfg_op_e           op;
    logic [SIDX_W-1:0] req_sector;
    logic              req_outer;
    logic              req_locked;
    logic              clr_permit;
    logic              deny;

    assign op = cfg_op_e'(cfg_op);

    sp_sector_decode #(
        .ADDR_W(ADDR_W), .BIG_W(BIG_W), .BOOT_W(BOOT_W),
        .OUTER_END(OUTER_END), .NSEC(NSEC), .SIDX_W(SIDX_W)
    ) decode_i (
        .addr(req_addr), .sector(req_sector), .is_outer(req_outer)
    );

    sp_pwd_ctrl #(.PWD_W(PWD_W)) pwd_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(op),
        .cfg_data(cfg_data), .clr_permit(clr_permit)
    );

    sp_lock_store #(.NSEC(NSEC), .SIDX_W(SIDX_W)) locks_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(op),
        .cfg_sector(cfg_sector), .clr_permit(clr_permit),
        .rd_sector(req_sector), .rd_locked(req_locked)
    );

    // Deny when any pin rule or the sector's lock bit applies.
    always_comb begin
        deny = !boost_n || (!outer_guard_n && req_outer) || req_locked;
    end

    // Register the verdict and sector number alongside the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_allow  <= 1'b0;
            rsp_sector <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_allow  <= !deny;
                rsp_sector <= req_sector;
            end
        end
    end

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_outer_denied_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !outer_guard_n && req_outer) |=> !rsp_allow);

    assert_boost_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !boost_n) |=> !rsp_allow);

    assert_sector_in_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_sector < SIDX_W'(NSEC));

endmodule

// File: tb/sp_write_guard_tb_top.sv
// Directed bench for the sector write-protection checker.
module sp_write_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [21:0] req_addr = '0;
    logic        outer_guard_n = 1'b1;
    logic        boost_n = 1'b1;
    logic        cfg_valid = 1'b0;
    logic [2:0]  cfg_op = '0;
    logic [7:0]  cfg_sector = '0;
    logic [63:0] cfg_data = '0;
    logic        rsp_valid;
    logic        rsp_allow;
    logic [7:0]  rsp_sector;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    localparam logic [63:0] PWD_A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] PWD_B = 64'hFEDC_BA98_7654_3210;

    always #2.5 clk = ~clk;

    sp_write_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .outer_guard_n(outer_guard_n), .boost_n(boost_n),
        .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_sector(cfg_sector),
        .cfg_data(cfg_data), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_sector(rsp_sector)
    );

    // Address of a large sector (8..133) as the requirement defines it.
    function automatic logic [21:0] big_addr(int s);
        return 22'((s - 7) << 15);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // Issue one request and check its registered verdict and sector.
    task automatic probe(string req, logic [21:0] a, int exp_sec, bit exp_allow);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, int'(rsp_valid), 1);
        check({req, " sector"}, int'(rsp_sector), exp_sec);
        check({req, " allow"}, int'(rsp_allow), int'(exp_allow));
    endtask

    task automatic cfg(logic [2:0] op, int sec, logic [63:0] data);
        @(negedge clk);
        cfg_valid  = 1'b1;
        cfg_op     = op;
        cfg_sector = 8'(sec);
        cfg_data   = data;
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_op    = 3'd0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R9 reset rsp_valid", int'(rsp_valid), 0);
        check("R9 reset rsp_allow", int'(rsp_allow), 0);
    endtask

    task automatic t_decode();
        probe("R1 first boot", 22'h000000, 0, 1);
        probe("R1 boot 1", 22'h001FFF, 1, 1);
        probe("R1 last low boot", 22'h007FFF, 7, 1);
        probe("R1 first large", 22'h008000, 8, 1);
        probe("R1 mid large", 22'h200000, 71, 1);
        probe("R1 last large", 22'h3F7FFF, 133, 1);
        probe("R1 first high boot", 22'h3F8000, 134, 1);
        probe("R1 top word", 22'h3FFFFF, 141, 1);
        @(negedge clk);
        check("R2 idle no rsp", int'(rsp_valid), 0);
    endtask

    task automatic t_outer_guard();
        outer_guard_n = 1'b0;
        probe("R3 s0", 22'h000000, 0, 0);
        probe("R3 s1", 22'h001000, 1, 0);
        probe("R3 s2 free", 22'h002000, 2, 1);
        probe("R3 s139 free", 22'h3FD000, 139, 1);
        probe("R3 s140", 22'h3FE000, 140, 0);
        probe("R3 s141", 22'h3FF000, 141, 0);
        outer_guard_n = 1'b1;
        probe("R3 released s0", 22'h000000, 0, 1);
    endtask

    task automatic t_boost();
        boost_n = 1'b0;
        probe("R4 large", big_addr(71), 71, 0);
        probe("R4 boot", 22'h002000, 2, 0);
        boost_n = 1'b1;
        probe("R4 released", big_addr(71), 71, 1);
    endtask

    task automatic t_locks();
        cfg(3'd1, 71, '0);
        probe("R5 locked s71", big_addr(71), 71, 0);
        probe("R5 neighbour s72", big_addr(72), 72, 1);
        cfg(3'd1, 200, '0);
        probe("R5 out of range lock no effect", big_addr(72), 72, 1);
        cfg(3'd2, 71, '0);
        probe("R6 freed s71", big_addr(71), 71, 1);
        cfg(3'd1, 3, '0);
        cfg(3'd1, 100, '0);
        probe("R11 locked s3", 22'h003000, 3, 0);
        cfg(3'd3, 0, '0);
        probe("R6 free all s3", 22'h003000, 3, 1);
        probe("R6 free all s100", big_addr(100), 100, 1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = 3'd1; cfg_sector = 8'd50;
        req_valid = 1'b1; req_addr = big_addr(50);
        @(negedge clk);
        cfg_valid = 1'b0; cfg_op = 3'd0; req_valid = 1'b0;
        check("R10 same-cycle allow", int'(rsp_allow), 1);
        probe("R10 next request denied", big_addr(50), 50, 0);
        cfg(3'd2, 50, '0);
        probe("R10 cleanup", big_addr(50), 50, 1);
    endtask

    task automatic t_password();
        cfg(3'd4, 0, PWD_A);
        cfg(3'd6, 0, '0);
        cfg(3'd1, 10, '0);
        cfg(3'd2, 10, '0);
        probe("R7 clear blocked", big_addr(10), 10, 0);
        cfg(3'd5, 0, PWD_B);
        cfg(3'd3, 0, '0);
        probe("R7 wrong try blocked", big_addr(10), 10, 0);
        cfg(3'd5, 0, PWD_A);
        cfg(3'd2, 10, '0);
        probe("R7 unlocked clear", big_addr(10), 10, 1);
        cfg(3'd1, 10, '0);
        cfg(3'd5, 0, 64'd5);
        cfg(3'd2, 10, '0);
        probe("R7 miss relocks latch", big_addr(10), 10, 0);
        cfg(3'd4, 0, PWD_B);
        cfg(3'd5, 0, PWD_A);
        do_reset();
        probe("R9 lock kept across reset", big_addr(10), 10, 0);
        cfg(3'd2, 10, '0);
        probe("R9 latch cleared by reset", big_addr(10), 10, 0);
        cfg(3'd5, 0, PWD_B);
        cfg(3'd2, 10, '0);
        probe("R8 load ignored in mode", big_addr(10), 10, 0);
        cfg(3'd5, 0, PWD_A);
        cfg(3'd2, 10, '0);
        probe("R8 stored password still valid", big_addr(10), 10, 1);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_outer_guard();
        t_boost();
        t_locks();
        t_same_cycle();
        t_password();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule